// File: doc/BRIEF.md
# Gated Coincidence Pattern Register

This block records which of sixteen channels fired while a common gate was open. On every clock edge, each channel input that is high together with the gate sets its own bit in a hit pattern. The bit stays set until something clears it. A global inhibit closes the gate, so no new bits can be latched while it is asserted.

The stored pattern is controlled through a crate-dataway style command port. That port carries a station select, a subaddress, a five-bit function code and a second strobe, each command lasting one clock cycle. Read commands put the pattern on the read bus and raise the Q acknowledge in the same cycle. Clears and the test-mode set-all act at the clock edge that ends a cycle in which the second strobe is high. An option input widens the Q response to the clear and test commands.

Two group counts report how many bits are set in each half of the pattern. They take the place of analog summing outputs for majority logic.

Top module: `coinc_pattern_reg`

## Requirements
- R1: At a clock edge where gate_i is 1 and inhibit_i is 0, every channel with hit_i[k]=1 gets its pattern bit k set. Bits already set stay set, so successive coincidences accumulate as a bitwise OR.
- R2: A channel input that is high while gate_i is 0 sets no bit.
- R3: While inhibit_i is 1, gate and hits set no bit.
- R4: Function code 0 with stn_sel_i=1 and sub_addr_i=0 drives rd_data_o with the pattern in the same cycle, bit k on rd_data_o[k], and drives q_o to 1.
- R5: Function code 2 with stn_sel_i=1 and sub_addr_i=0 reads like R4. It clears the pattern at the closing edge only when strobe2_i is 1; without strobe2_i the pattern is kept.
- R6: Function code 9 with stn_sel_i=1, sub_addr_i=0 and strobe2_i=1 clears the pattern. It drives q_o to 1 only when q_opt_i is 1.
- R7: Function code 25 with stn_sel_i=1 and strobe2_i=1 sets all sixteen bits for any subaddress. It drives q_o to 1 only when q_opt_i=1 and sub_addr_i=0.
- R8: init_i or dclr_i together with strobe2_i clears the pattern, without regard to station select. Either one without strobe2_i has no effect.
- R9: panel_clr_i=1 clears the pattern at the next edge.
- R10: Priority at an edge, highest first: set-all, then any clear, then coincidence latching.
- R11: rd_data_o is 0 and q_o is 0 whenever neither R4 nor R5 applies, unless R6 or R7 raises q_o. This covers commands without station select, other function codes and nonzero subaddresses, and such commands change nothing.
- R12: grp_cnt_o[3:0] equals the number of set bits among pattern bits 0 to 7. grp_cnt_o[7:4] equals the number of set bits among bits 8 to 15. Both follow the pattern with no added delay.
- R13: A synchronous active-low reset empties the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 16 | Channel inputs |
| gate_i | input | 1 | Common coincidence gate |
| inhibit_i | input | 1 | Dataway inhibit, blocks the gate |
| panel_clr_i | input | 1 | Front-panel clear |
| stn_sel_i | input | 1 | Station select |
| sub_addr_i | input | 4 | Subaddress |
| func_i | input | 5 | Function code |
| strobe2_i | input | 1 | Second strobe, qualifies clears and set-all |
| init_i | input | 1 | Dataway initialize |
| dclr_i | input | 1 | Dataway clear |
| q_opt_i | input | 1 | Extends Q to clear and test commands |
| rd_data_o | output | 16 | Read bus |
| q_o | output | 1 | Command acknowledge |
| grp_cnt_o | output | 8 | Set-bit count per group of 8 channels |

## Verification
rd_data_o and q_o are combinational from the command and the stored pattern. The bench samples them one time unit after driving a command, while the command cycle is still open and before the edge that could clear the pattern. Pattern changes from coincidence, clear or set-all are due at the single edge that closes the stimulus cycle, and grp_cnt_o follows in that same cycle. Those results are checked at the following falling edge, and a later read command confirms the full pattern. The sweep covers every function code at several subaddresses, with and without station select and with both settings of the option input, and each expected value comes from a plain model of the requirements.

// File: rtl/coinc_pkg.sv
// Shared constants for the coincidence pattern register.
// Assumes a five-bit function code on the command port.
package coinc_pkg;
    localparam int FW = 5;
    localparam logic [FW-1:0] FN_READ     = 5'd0;
    localparam logic [FW-1:0] FN_READ_CLR = 5'd2;
    localparam logic [FW-1:0] FN_CLEAR    = 5'd9;
    localparam logic [FW-1:0] FN_TEST     = 5'd25;
endpackage

// File: rtl/coinc_cmd_decode.sv
// Decodes one single-cycle dataway command into read enable, Q, clear and
// set-all requests. Assumes strobe2_i is high only in a cycle that should
// act on the register at its closing edge.
module coinc_cmd_decode
    import coinc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          stn_sel_i,
    input  logic [AW-1:0] sub_addr_i,
    input  logic [FW-1:0] func_i,
    input  logic          strobe2_i,
    input  logic          init_i,
    input  logic          dclr_i,
    input  logic          panel_clr_i,
    input  logic          q_opt_i,
    output logic          rd_en_o,
    output logic          q_o,
    output logic          clr_o,
    output logic          set_all_o
);
    logic addr_ok;
    logic is_rd, is_rdc, is_clr, is_tst;

    // Classify the command and build the requests.
    always_comb begin
        addr_ok   = stn_sel_i && (sub_addr_i == '0);
        is_rd     = (func_i == FN_READ);
        is_rdc    = (func_i == FN_READ_CLR);
        is_clr    = (func_i == FN_CLEAR);
        is_tst    = (func_i == FN_TEST);
        rd_en_o   = addr_ok && (is_rd || is_rdc);
        q_o       = rd_en_o || (q_opt_i && addr_ok && (is_clr || is_tst));
        set_all_o = stn_sel_i && strobe2_i && is_tst;
        clr_o     = panel_clr_i
                  || (strobe2_i && (init_i || dclr_i))
                  || (strobe2_i && addr_ok && (is_rdc || is_clr));
    end
endmodule

// File: rtl/coinc_store.sv
// Hit pattern storage. Sets bits on coincidence of a hit with the open gate,
// with set-all ranked above clear and clear ranked above latching.
// Assumes the gate is already qualified by inhibit.
module coinc_store #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_i,
    input  logic           gate_open_i,
    input  logic           clr_i,
    input  logic           set_all_i,
    output logic [NCH-1:0] pat_o
);
    logic [NCH-1:0] pat_q;

    // Update the stored pattern according to the priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pat_q <= '0;
        else if (set_all_i)
            pat_q <= '1;
        else if (clr_i)
            pat_q <= '0;
        else if (gate_open_i)
            pat_q <= pat_q | hit_i;
    end

    assign pat_o = pat_q;
endmodule

// File: rtl/coinc_group_count.sv
// Counts set bits in each group of GRP consecutive pattern bits.
// Assumes NCH is a multiple of GRP.
module coinc_group_count #(
    parameter int NCH = 16,
    parameter int GRP = 8,
    localparam int NGRP = NCH / GRP,
    localparam int CW   = $clog2(GRP + 1)
) (
    input  logic [NCH-1:0]     pat_i,
    output logic [NGRP*CW-1:0] cnt_o
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [CW-1:0] sum;
        // Add the bits of this group.
        always_comb begin
            sum = '0;
            for (int b = 0; b < GRP; b++)
                sum = sum + CW'(pat_i[g*GRP+b]);
        end
        assign cnt_o[g*CW +: CW] = sum;
    end
endmodule

// File: rtl/coinc_pattern_reg.sv
// Top of the gated coincidence pattern register: command decode, pattern
// storage and per-group counts. Assumes single-cycle command pulses.
module coinc_pattern_reg
    import coinc_pkg::*;
#(
    parameter int NCH = 16,
    parameter int GRP = 8,
    parameter int AW  = 4,
    localparam int NGRP = NCH / GRP,
    localparam int CW   = $clog2(GRP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     hit_i,
    input  logic               gate_i,
    input  logic               inhibit_i,
    input  logic               panel_clr_i,
    input  logic               stn_sel_i,
    input  logic [AW-1:0]      sub_addr_i,
    input  logic [FW-1:0]      func_i,
    input  logic               strobe2_i,
    input  logic               init_i,
    input  logic               dclr_i,
    input  logic               q_opt_i,
    output logic [NCH-1:0]     rd_data_o,
    output logic               q_o,
    output logic [NGRP*CW-1:0] grp_cnt_o
);
    logic           rd_en, clr, set_all;
    logic [NCH-1:0] pat;

    coinc_cmd_decode #(.AW(AW)) u_dec (
        .stn_sel_i  (stn_sel_i),
        .sub_addr_i (sub_addr_i),
        .func_i     (func_i),
        .strobe2_i  (strobe2_i),
        .init_i     (init_i),
        .dclr_i     (dclr_i),
        .panel_clr_i(panel_clr_i),
        .q_opt_i    (q_opt_i),
        .rd_en_o    (rd_en),
        .q_o        (q_o),
        .clr_o      (clr),
        .set_all_o  (set_all)
    );

    coinc_store #(.NCH(NCH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit_i),
        .gate_open_i(gate_i && !inhibit_i),
        .clr_i      (clr),
        .set_all_i  (set_all),
        .pat_o      (pat)
    );

    coinc_group_count #(.NCH(NCH), .GRP(GRP)) u_cnt (
        .pat_i(pat),
        .cnt_o(grp_cnt_o)
    );

    // Drive the read bus only during a valid read.
    always_comb rd_data_o = rd_en ? pat : '0;
endmodule

// File: rtl/coinc_pattern_reg_chk.sv
// Checker for the coincidence pattern register, bound to the top module.
module coinc_pattern_reg_chk #(
    parameter int NCH = 16,
    parameter int GRP = 8,
    parameter int AW  = 4,
    parameter int FW  = 5,
    parameter int CWD = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] hit_i,
    input logic           gate_i,
    input logic           inhibit_i,
    input logic           panel_clr_i,
    input logic           stn_sel_i,
    input logic [AW-1:0]  sub_addr_i,
    input logic [FW-1:0]  func_i,
    input logic           strobe2_i,
    input logic           init_i,
    input logic           dclr_i,
    input logic [NCH-1:0] rd_data_o,
    input logic           q_o,
    input logic [CWD-1:0] grp_cnt_o,
    input logic [NCH-1:0] pat
);
    logic sel0, rd_cmd, any_clr, any_set;
    always_comb begin
        sel0    = stn_sel_i && (sub_addr_i == '0);
        rd_cmd  = sel0 && (func_i == 5'd0 || func_i == 5'd2);
        any_set = stn_sel_i && strobe2_i && (func_i == 5'd25);
        any_clr = panel_clr_i || (strobe2_i && (init_i || dclr_i))
               || (strobe2_i && sel0 && (func_i == 5'd2 || func_i == 5'd9));
    end

    // R1
    latch_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && !inhibit_i && !any_clr && !any_set)
        |=> ((pat & $past(hit_i)) == $past(hit_i)) && ((pat & $past(pat)) == $past(pat)));

    // R3
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_i && !any_clr && !any_set) |=> pat == $past(pat));

    // R7
    set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_set |=> pat == '1);

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_clr && !any_set) |=> pat == '0);

    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cmd |-> rd_data_o == '0);

    // R11
    no_station_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stn_sel_i |-> !q_o);

    // R4
    read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |-> (q_o && rd_data_o == pat));

    // R12
    group_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_cnt_o[3:0] == 4'($countones(pat[7:0])))
        && (grp_cnt_o[7:4] == 4'($countones(pat[15:8]))));
endmodule

bind coinc_pattern_reg coinc_pattern_reg_chk #(
    .NCH(NCH), .GRP(GRP), .AW(AW), .FW(5), .CWD(NGRP*CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .gate_i(gate_i),
    .inhibit_i(inhibit_i), .panel_clr_i(panel_clr_i), .stn_sel_i(stn_sel_i),
    .sub_addr_i(sub_addr_i), .func_i(func_i), .strobe2_i(strobe2_i),
    .init_i(init_i), .dclr_i(dclr_i), .rd_data_o(rd_data_o), .q_o(q_o),
    .grp_cnt_o(grp_cnt_o), .pat(pat)
);

// File: tb/coinc_pattern_reg_tb.sv
// Self-checking bench: directed corner cases plus a sweep over function
// codes, subaddresses, station select and the Q option.
module coinc_pattern_reg_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] hit_i;
    logic        gate_i, inhibit_i, panel_clr_i, stn_sel_i;
    logic [3:0]  sub_addr_i;
    logic [4:0]  func_i;
    logic        strobe2_i, init_i, dclr_i, q_opt_i;
    logic [15:0] rd_data_o;
    logic        q_o;
    logic [7:0]  grp_cnt_o;

    int n_chk = 0, n_fail = 0;
    logic        done = 1'b0;
    logic [15:0] model;

    always #(CLK_P/2) clk = ~clk;

    coinc_pattern_reg u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .gate_i(gate_i),
        .inhibit_i(inhibit_i), .panel_clr_i(panel_clr_i), .stn_sel_i(stn_sel_i),
        .sub_addr_i(sub_addr_i), .func_i(func_i), .strobe2_i(strobe2_i),
        .init_i(init_i), .dclr_i(dclr_i), .q_opt_i(q_opt_i),
        .rd_data_o(rd_data_o), .q_o(q_o), .grp_cnt_o(grp_cnt_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        hit_i = '0; gate_i = 0; inhibit_i = 0; panel_clr_i = 0; stn_sel_i = 0;
        sub_addr_i = '0; func_i = '0; strobe2_i = 0; init_i = 0; dclr_i = 0;
    endtask

    // Advance through one edge and return to the next falling edge.
    task automatic cyc();
        @(negedge clk);
    endtask

    // Verify the pattern via a read command and via the group counts.
    task automatic verify(input string tag);
        check({tag, " cnt"}, {24'd0, grp_cnt_o},
              {24'd0, 4'($countones(model[15:8])), 4'($countones(model[7:0]))});
        idle(); stn_sel_i = 1; func_i = 5'd0;
        #1;
        check({tag, " rd"}, {16'd0, rd_data_o}, {16'd0, model});
        cyc(); idle();
    endtask

    task automatic load(input logic [15:0] v);
        idle(); panel_clr_i = 1; cyc();
        idle(); gate_i = 1; hit_i = v; cyc(); idle();
        model = v;
    endtask

    initial begin
        idle(); q_opt_i = 0; rst_n = 0;
        model = '0;
        repeat (3) cyc();
        rst_n = 1;
        // R13: reset empties the pattern
        verify("R13 reset");

        // R1: coincidence latch and OR accumulation
        gate_i = 1; hit_i = 16'h0081; cyc(); idle(); model = 16'h0081;
        verify("R1 first");
        gate_i = 1; hit_i = 16'h8100; cyc(); idle(); model = 16'h8181;
        verify("R1 accumulate");
        // R2: hits without gate
        hit_i = 16'h7E7E; cyc(); idle();
        verify("R2 no gate");
        // R3: inhibit blocks gate
        gate_i = 1; inhibit_i = 1; hit_i = 16'hFFFF; cyc(); idle();
        verify("R3 inhibit");
        // R9: front-panel clear
        panel_clr_i = 1; cyc(); idle(); model = '0;
        verify("R9 panel clear");
        // R10: clear beats latch
        load(16'h00F0);
        panel_clr_i = 1; gate_i = 1; hit_i = 16'h0F0F; cyc(); idle(); model = '0;
        verify("R10 clear over latch");
        // R10: set-all beats clear
        panel_clr_i = 1; stn_sel_i = 1; func_i = 5'd25; strobe2_i = 1; sub_addr_i = 4'd3;
        cyc(); idle(); model = 16'hFFFF;
        verify("R10 set over clear");
        // R8: Z and C need S2
        load(16'h1234);
        init_i = 1; cyc(); idle();
        verify("R8 init no S2");
        dclr_i = 1; cyc(); idle();
        verify("R8 dclr no S2");
        dclr_i = 1; strobe2_i = 1; cyc(); idle(); model = '0;
        verify("R8 dclr S2");
        load(16'h4321);
        init_i = 1; strobe2_i = 1; cyc(); idle(); model = '0;
        verify("R8 init S2");
        // R5: read-and-clear without S2 keeps data
        load(16'hA5A5);
        stn_sel_i = 1; func_i = 5'd2; #1;
        check("R5 rd no S2", {16'd0, rd_data_o}, 32'h0000A5A5);
        cyc(); idle();
        verify("R5 keep");

        // Sweep over commands (R4 R5 R6 R7 R11 R12)
        for (int qo = 0; qo < 2; qo++) begin
            q_opt_i = qo[0];
            for (int f = 0; f < 32; f++) begin
                for (int ai = 0; ai < 3; ai++) begin
                    for (int n = 0; n < 2; n++) begin
                        logic [3:0]  a;
                        logic [15:0] seed;
                        logic        rdv, eq;
                        a = (ai == 0) ? 4'd0 : (ai == 1) ? 4'd1 : 4'd15;
                        seed = (16'(f) * 16'h9E37) ^ (16'(ai) << 11) ^ 16'(n * 16'h0301);
                        load(seed);
                        rdv = (n == 1) && (a == 0) && (f == 0 || f == 2);
                        eq  = rdv || (qo == 1 && n == 1 && a == 0 && (f == 9 || f == 25));
                        stn_sel_i = n[0]; sub_addr_i = a; func_i = 5'(f); strobe2_i = 1;
                        #1;
                        check($sformatf("R11 q f=%0d a=%0d n=%0d o=%0d", f, a, n, qo),
                              {31'd0, q_o}, {31'd0, eq});
                        check($sformatf("R4 rd f=%0d a=%0d n=%0d", f, a, n),
                              {16'd0, rd_data_o}, {16'd0, rdv ? seed : 16'h0000});
                        cyc(); idle();
                        if (n == 1 && f == 25) model = 16'hFFFF;
                        else if (n == 1 && a == 0 && (f == 2 || f == 9)) model = '0;
                        check($sformatf("R12 cnt f=%0d a=%0d n=%0d", f, a, n),
                              {24'd0, grp_cnt_o},
                              {24'd0, 4'($countones(model[15:8])), 4'($countones(model[7:0]))});
                        if (f == 2 || f == 9 || f == 25) verify("R6 R7 effect");
                    end
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule